// File: doc/BRIEF.md
# Interrupt Pending and In-Service Tracker

This block records interrupt requests for 256 vectors and follows each one from arrival to completion. Two 256-bit arrays hold the state. The waiting array holds requests that have not been delivered yet. The active array marks the vectors the processor is handling now.

A request is an 8-bit vector number qualified by a valid strobe. It sets that vector's waiting bit. The top four bits of a vector number give its priority class. The highest waiting vector is offered to the processor only when its class is strictly above the class of the highest active vector, or when no vector is active.

When the processor takes the offer with the accept strobe, the vector leaves the waiting array and enters the active array. An end-of-service strobe retires the highest active vector. Software reads both arrays as eight 32-bit words each, placed on a 16-byte stride.

Top module: `irq_vec_tracker`

## Requirements
- R1: After reset both arrays are empty, `irq_o` is low, `irq_vec_o` is 0, and every read returns 0.
- R2: A cycle with `req_valid_i` high sets the waiting bit of `req_vec_i`, visible from the next cycle. A repeated request for a bit that is already waiting changes nothing. A request stays waiting until it is accepted.
- R3: `irq_o` is high exactly when the waiting array is not empty and either the active array is empty or the class (vector bits 7:4) of the highest waiting vector is strictly greater than that of the highest active vector.
- R4: `irq_vec_o` always shows the highest waiting vector number, and shows 0 when nothing is waiting.
- R5: `ack_i` sampled while `irq_o` is high does two things, both visible in the next cycle: it clears the waiting bit of `irq_vec_o` and sets its active bit. `ack_i` sampled while `irq_o` is low has no effect.
- R6: `eoi_i` clears only the highest set active bit. With the active array empty it has no effect.
- R7: The active word k (k = 0..7) reads at byte offset 0x100 + 16·k and the waiting word k at 0x200 + 16·k. Bit b of word k stands for vector 32·k + b. `bus_rdata_o` follows `bus_addr_i` combinationally.
- R8: Every offset outside those sixteen reads 0, including offsets with nonzero bits 3:0 and offsets with bit 7 set.
- R9: Bus writes (`bus_we_i` high) leave both arrays unchanged.
- R10: If a request for vector v and an accept of v arrive in the same cycle, v becomes active and also stays waiting.
- R11: An `eoi_i` and a valid `ack_i` in the same cycle both take effect: the old highest active bit clears and the newly accepted vector becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector number |
| irq_o | output | 1 | Offer to the processor |
| irq_vec_o | output | 8 | Highest waiting vector |
| ack_i | input | 1 | Processor takes the offered vector |
| eoi_i | input | 1 | Retire the highest active vector |
| bus_addr_i | input | 12 | Register byte offset |
| bus_we_i | input | 1 | Write strobe (ignored) |
| bus_wdata_i | input | 32 | Write data (ignored) |
| bus_rdata_o | output | 32 | Read data |

## Verification
The assertions assume a few things about the processor side. `ack_i` carries meaning only while `irq_o` is high. `eoi_i` is issued only for a vector that was accepted earlier, so a valid accept never lands on the bit that an end-of-service clears in the same cycle.

The stimulus respects these rules. Every input is driven on the falling edge and held for one full cycle. Only one ignored accept is injected, at a point where `irq_o` is known to be low. Same-cycle accept and end-of-service pairs are placed so that their two vectors differ by class.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned NUM_VEC   = 1 << VEC_W;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CLASS_W   = 4;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned ISR_PAGE  = 1;
  localparam int unsigned PEND_PAGE = 2;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int unsigned N_VEC  = irq_trk_pkg::NUM_VEC,
  parameter int unsigned WORD_W = irq_trk_pkg::WORD_W,
  localparam int unsigned VW    = $clog2(N_VEC),
  localparam int unsigned N_WORD = N_VEC / WORD_W,
  localparam int unsigned BW    = $clog2(WORD_W)
) (
  input  logic [N_VEC-1:0] bits_i,
  output logic [VW-1:0]    idx_o,
  output logic             found_o
);
  logic [N_WORD-1:0] word_any;
  logic [BW-1:0]     word_top [N_WORD];

  // first level: highest set bit inside each word
  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    always_comb begin
      word_any[w] = 1'b0;
      word_top[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits_i[w*WORD_W + b]) begin
          word_any[w] = 1'b1;
          word_top[w] = BW'(b);
        end
      end
    end
  end

  // second level: scan words, the last nonzero one wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int w = 0; w < N_WORD; w++) begin
      if (word_any[w]) begin
        found_o = 1'b1;
        idx_o   = VW'(w * WORD_W) | VW'(word_top[w]);
      end
    end
  end
endmodule

// File: rtl/vec_bitmap.sv
module vec_bitmap #(
  parameter int unsigned N_VEC = irq_trk_pkg::NUM_VEC,
  localparam int unsigned VW   = $clog2(N_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [VW-1:0]    set_idx_i,
  input  logic             clr_en_i,
  input  logic [VW-1:0]    clr_idx_i,
  output logic [N_VEC-1:0] bits_o
);
  logic [N_VEC-1:0] set_mask, clr_mask, bits_d;

  always_comb begin
    set_mask = set_en_i ? ({{(N_VEC-1){1'b0}}, 1'b1} << set_idx_i) : '0;
    clr_mask = clr_en_i ? ({{(N_VEC-1){1'b0}}, 1'b1} << clr_idx_i) : '0;
    // a set in the same cycle as a clear of the same bit wins
    bits_d   = (bits_o & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= bits_d;
  end

  // R2
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> bits_o[$past(set_idx_i)]);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(bits_o));
endmodule

// File: rtl/irq_reg_rd.sv
module irq_reg_rd #(
  parameter int unsigned N_VEC     = irq_trk_pkg::NUM_VEC,
  parameter int unsigned WORD_W    = irq_trk_pkg::WORD_W,
  parameter int unsigned ADDR_W    = irq_trk_pkg::ADDR_W,
  parameter int unsigned ISR_PAGE  = irq_trk_pkg::ISR_PAGE,
  parameter int unsigned PEND_PAGE = irq_trk_pkg::PEND_PAGE,
  localparam int unsigned N_WORD   = N_VEC / WORD_W,
  localparam int unsigned WI_W     = $clog2(N_WORD)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_VEC-1:0]  isr_i,
  input  logic [N_VEC-1:0]  pend_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [ADDR_W-9:0] page;
  logic [WI_W-1:0]   widx;
  logic              on_grid;

  assign page    = addr_i[ADDR_W-1:8];
  assign widx    = addr_i[4 +: WI_W];
  // word slot only where the low nibble is zero and above the index field is clear
  assign on_grid = (addr_i[3:0] == 4'h0) && (addr_i[7:4+WI_W] == '0);

  always_comb begin
    rdata_o = '0;
    if (on_grid) begin
      if (page == (ADDR_W-8)'(ISR_PAGE))       rdata_o = isr_i[widx*WORD_W +: WORD_W];
      else if (page == (ADDR_W-8)'(PEND_PAGE)) rdata_o = pend_i[widx*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker
  import irq_trk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o
);
  logic [NUM_VEC-1:0] pend_q, isr_q;
  logic [VEC_W-1:0]   pend_top, isr_top;
  logic               pend_any, isr_any;
  logic               take;
  logic               retire;
  logic               unused_bus;

  // register writes have no effect on either array
  assign unused_bus = ^{bus_we_i, bus_wdata_i};

  vec_prio_enc #(.N_VEC(NUM_VEC), .WORD_W(WORD_W)) i_pend_enc (
    .bits_i(pend_q), .idx_o(pend_top), .found_o(pend_any));

  vec_prio_enc #(.N_VEC(NUM_VEC), .WORD_W(WORD_W)) i_isr_enc (
    .bits_i(isr_q), .idx_o(isr_top), .found_o(isr_any));

  assign irq_o = pend_any &&
                 (!isr_any || (pend_top[VEC_W-1 -: CLASS_W] > isr_top[VEC_W-1 -: CLASS_W]));
  assign irq_vec_o = pend_top;
  assign take      = ack_i && irq_o;
  assign retire    = eoi_i && isr_any;

  vec_bitmap #(.N_VEC(NUM_VEC)) i_pend (
    .clk_i, .rst_ni,
    .set_en_i(req_valid_i), .set_idx_i(req_vec_i),
    .clr_en_i(take),        .clr_idx_i(pend_top),
    .bits_o(pend_q));

  vec_bitmap #(.N_VEC(NUM_VEC)) i_isr (
    .clk_i, .rst_ni,
    .set_en_i(take),   .set_idx_i(pend_top),
    .clr_en_i(retire), .clr_idx_i(isr_top),
    .bits_o(isr_q));

  irq_reg_rd #(
    .N_VEC(NUM_VEC), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .ISR_PAGE(ISR_PAGE), .PEND_PAGE(PEND_PAGE)
  ) i_rd (
    .addr_i(bus_addr_i), .isr_i(isr_q), .pend_i(pend_q), .rdata_o(bus_rdata_o));

  // R3
  offer_waiting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_q[irq_vec_o] && !isr_q[irq_vec_o]));

  // R5
  take_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> isr_q[$past(irq_vec_o)]);

  // R5
  take_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !(req_valid_i && req_vec_i == irq_vec_o)) |=> !pend_q[$past(irq_vec_o)]);

  // R6
  eoi_clears_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |=> !isr_q[$past(isr_top)]);

  // R6
  eoi_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire && !take) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/test_irq_vec_tracker.sv
module test_irq_vec_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N_STEP = 20;
  // {op(0 req,1 ack,2 eoi), vec, expected irq_o, expected irq_vec_o}
  localparam logic [18:0] TBL [N_STEP] = '{
    {2'd0, 8'h31, 1'b1, 8'h31},
    {2'd0, 8'h52, 1'b1, 8'h52},
    {2'd1, 8'h00, 1'b0, 8'h31},
    {2'd0, 8'h58, 1'b0, 8'h58},
    {2'd0, 8'h61, 1'b1, 8'h61},
    {2'd1, 8'h00, 1'b0, 8'h58},
    {2'd2, 8'h00, 1'b0, 8'h58},
    {2'd2, 8'h00, 1'b1, 8'h58},
    {2'd1, 8'h00, 1'b0, 8'h31},
    {2'd1, 8'h00, 1'b0, 8'h31},
    {2'd2, 8'h00, 1'b1, 8'h31},
    {2'd1, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd0, 8'hFF, 1'b1, 8'hFF},
    {2'd0, 8'h00, 1'b1, 8'hFF},
    {2'd1, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd1, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic        irq_o;
  logic [7:0]  irq_vec_o;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_vec_tracker i_irq_vec_tracker (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic rq, input logic [7:0] v, input logic ak, input logic eo);
    @(negedge clk_i);
    req_valid_i = rq; req_vec_i = v; ack_i = ak; eoi_i = eo;
    @(negedge clk_i);
    req_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr_i = a;
    #1;
    chk(tag, bus_rdata_o, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_we_i = 1'b1; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 vec", {24'd0, irq_vec_o}, 32'd0);
    rd("R1 rd isr", 12'h100, 32'd0);
    rd("R1 rd pend", 12'h270, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_STEP; i++) begin
      case (TBL[i][18:17])
        2'd0: cyc(1'b1, TBL[i][16:9], 1'b0, 1'b0); // R2
        2'd1: cyc(1'b0, 8'h00, 1'b1, 1'b0);        // R5
        default: cyc(1'b0, 8'h00, 1'b0, 1'b1);     // R6
      endcase
      chk($sformatf("R3 step %0d irq", i), {31'd0, irq_o}, {31'd0, TBL[i][8]});
      chk($sformatf("R4 step %0d vec", i), {24'd0, irq_vec_o}, {24'd0, TBL[i][7:0]});
    end

    // R7 word layout
    cyc(1'b1, 8'h45, 1'b0, 1'b0);
    cyc(1'b1, 8'h07, 1'b0, 1'b0);
    rd("R7 pend word2", 12'h220, 32'h0000_0020);
    rd("R7 pend word0", 12'h200, 32'h0000_0080);
    rd("R7 isr word2", 12'h120, 32'd0);
    // R8 gaps
    rd("R8 low nibble", 12'h224, 32'd0);
    rd("R8 bit7", 12'h2A0, 32'd0);
    rd("R8 other page", 12'h320, 32'd0);
    // R9 writes ignored
    wr(12'h220, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd("R9 pend kept", 12'h220, 32'h0000_0020);
    rd("R9 isr kept", 12'h100, 32'd0);
    chk("R9 irq", {31'd0, irq_o}, 32'd1);
    // R2 duplicate request
    cyc(1'b1, 8'h07, 1'b0, 1'b0);
    rd("R2 dup", 12'h200, 32'h0000_0080);
    // R10 request and accept of same vector
    cyc(1'b1, 8'h45, 1'b1, 1'b0);
    rd("R10 pend", 12'h220, 32'h0000_0020);
    rd("R10 isr", 12'h120, 32'h0000_0020);
    chk("R10 irq", {31'd0, irq_o}, 32'd0);
    // R11 accept and retire in one cycle
    cyc(1'b1, 8'h91, 1'b0, 1'b0);
    chk("R11 offer", {23'd0, irq_o, irq_vec_o}, 32'h191);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    rd("R11 old cleared", 12'h120, 32'd0);
    rd("R11 new set", 12'h140, 32'h0002_0000);
    chk("R11 irq", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule